// File: doc/BRIEF.md
# Processor Reset Vector Sequencer

This block brings a processor core out of reset. While reset is held it presents the architectural reset values of the control registers. The status word is supervisor mode with the interrupt mask at its highest level. The vector base is zero. Both function-code registers hold 5. After reset is released, the block reads two long words from memory over a plain 32-bit read port. The first, at address 0, becomes the initial supervisor stack pointer. The second, at address 4, becomes the initial program counter.

The read port uses a request/ready handshake with a separate error flag. The sequencer keeps its request and address steady until the memory side answers. A read that comes back with the error flag set does not load its data: the register it was meant to fill is loaded with zero. When both vectors are in place, the block raises `done` for one cycle and then holds `running` high. From then on it ignores the read port completely until the next reset.

The sequencer is a five-state machine, walking through the states in this order:

- `ST_BOOT` is the reset state. It moves on unconditionally to `ST_SP_FETCH`.
- `ST_SP_FETCH` moves to `ST_PC_FETCH` when its read completes.
- `ST_PC_FETCH` moves to `ST_ANNOUNCE` when its read completes.
- `ST_ANNOUNCE` moves on unconditionally to `ST_RUN`.
- `ST_RUN` loops to itself.

A read completes when a request is out and either `rd_ready` or `rd_err` is high at a clock edge.

Top module: `rstvec_seq`

## Requirements
- R1: While reset is asserted and at all times afterwards, `sr_out` is 0x2700 (bit 13 supervisor set, bits 10:8 interrupt mask = 7, all else 0), and `vbr_out` is 0.
- R2: While reset is asserted and at all times afterwards, `sfc_out` and `dfc_out` both read 5.
- R3: No request is issued while reset is asserted. The first read request after reset targets address 0x0000000 on the 28-bit `rd_addr`.
- R4: The second read request targets address 0x0000004, and it is issued only after the first read has completed.
- R5: A read that completes with `rd_ready` high and `rd_err` low loads `rd_data`. The first read loads `ssp_out` and the second loads `pc_out`, each visible from the edge after completion.
- R6: A read that completes with `rd_err` high loads zero into its register, whether `rd_ready` is high or not.
- R7: `done` is high for exactly one cycle, the cycle after the second read completes, and never again until the next reset.
- R8: `running` is low until `done` has been seen. It goes high in the cycle after `done` and stays high.
- R9: While a request is outstanding without `rd_ready` or `rd_err`, `rd_req` stays high and `rd_addr` stays unchanged.
- R10: Once `running` is high, `rd_req` stays low. Activity on `rd_ready`, `rd_err` or `rd_data` then leaves `ssp_out` and `pc_out` unchanged and raises no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | output | 1 | Read request valid |
| rd_addr | output | 28 | Long-word read address |
| rd_ready | input | 1 | Read data valid, completes the read |
| rd_err | input | 1 | Read faulted, completes the read |
| rd_data | input | 32 | Read data |
| sr_out | output | 16 | Status register reset value |
| vbr_out | output | 32 | Vector base register |
| sfc_out | output | 3 | Source function-code register |
| dfc_out | output | 3 | Destination function-code register |
| ssp_out | output | 32 | Initial supervisor stack pointer |
| pc_out | output | 32 | Initial program counter |
| done | output | 1 | One-cycle pulse when both vectors are loaded |
| running | output | 1 | High in the normal run state |

## Verification
The hardest cases to reach are the ones where a read faults, particularly when `rd_err` and `rd_ready` arrive together and nonzero garbage is on `rd_data`. The bench's memory responder can be set per vector to answer cleanly, with an error alone, or with error and ready together, and it has a configurable wait latency, so the stall path is covered as well. After each run completes, the responder switches to a noise mode. In that mode it toggles the handshake and data freely, which shows that the running state really does ignore the port.

// File: rtl/rstvec_pkg.sv
package rstvec_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_SP_FETCH,
        ST_PC_FETCH,
        ST_ANNOUNCE,
        ST_RUN
    } rv_state_t;

    localparam int unsigned NUM_VEC = 2;
    localparam int unsigned VEC_SP  = 0;
    localparam int unsigned VEC_PC  = 1;

endpackage

// File: rtl/rstvec_fsm.sv
module rstvec_fsm
    import rstvec_pkg::*;
#(
    parameter int unsigned ADDR_W = 28,
    parameter int unsigned DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_ready,
    input  logic               rd_err,
    output logic               rd_req,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic [NUM_VEC-1:0] cap,
    output logic               done,
    output logic               running
);
    localparam int unsigned STRIDE = DATA_W / 8;
    localparam logic [ADDR_W-1:0] SP_ADDR = ADDR_W'(VEC_SP * STRIDE);
    localparam logic [ADDR_W-1:0] PC_ADDR = ADDR_W'(VEC_PC * STRIDE);

    rv_state_t state_q, state_d;
    logic      hs;

    assign hs = rd_req && (rd_ready || rd_err);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:     state_d = ST_SP_FETCH;
            ST_SP_FETCH: if (hs) state_d = ST_PC_FETCH;
            ST_PC_FETCH: if (hs) state_d = ST_ANNOUNCE;
            ST_ANNOUNCE: state_d = ST_RUN;
            ST_RUN:      state_d = ST_RUN;
            default:     state_d = ST_BOOT;
        endcase
    end

    always_comb begin
        rd_req  = 1'b0;
        rd_addr = '0;
        cap     = '0;
        done    = 1'b0;
        running = 1'b0;
        unique case (state_q)
            ST_SP_FETCH: begin
                rd_req      = 1'b1;
                rd_addr     = SP_ADDR;
                cap[VEC_SP] = hs;
            end
            ST_PC_FETCH: begin
                rd_req      = 1'b1;
                rd_addr     = PC_ADDR;
                cap[VEC_PC] = hs;
            end
            ST_ANNOUNCE: done    = 1'b1;
            ST_RUN:      running = 1'b1;
            default: ;
        endcase
    end

    // R9: an unanswered request keeps its request and address
    assert_hold_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ready && !rd_err) |=> (rd_req && $stable(rd_addr)));

    // R7: done lasts one cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: run state follows done
    assert_run_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> running);

    // R10: run state is sticky and silent on the port
    assert_run_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> (running && !rd_req && !done));

    // R4: the program counter request follows a completed stack pointer read
    assert_pc_after_sp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_addr == SP_ADDR && (rd_ready || rd_err)) |=>
        (rd_req && rd_addr == PC_ADDR));

endmodule

// File: rtl/rstvec_vecreg.sv
module rstvec_vecreg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              err,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (cap) q <= err ? '0 : data;
    end

    // R6: faulted read loads zero
    assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && err) |=> (q == '0));

    // R5: clean read loads the data
    assert_clean_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !err) |=> (q == $past(data)));

endmodule

// File: rtl/rstvec_ctlregs.sv
module rstvec_ctlregs #(
    parameter int unsigned SR_W     = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned FC_W     = 3,
    parameter logic [SR_W-1:0] SR_INIT = 16'h2700,
    parameter logic [FC_W-1:0] FC_INIT = 3'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SR_W-1:0]   sr_q,
    output logic [DATA_W-1:0] vbr_q,
    output logic [FC_W-1:0]   sfc_q,
    output logic [FC_W-1:0]   dfc_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= SR_INIT;
            vbr_q <= '0;
            sfc_q <= FC_INIT;
            dfc_q <= FC_INIT;
        end
    end

endmodule

// File: rtl/rstvec_seq.sv
module rstvec_seq
    import rstvec_pkg::*;
#(
    parameter int unsigned ADDR_W = 28,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SR_W   = 16,
    parameter int unsigned FC_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic              rd_err,
    input  logic [DATA_W-1:0] rd_data,
    output logic [SR_W-1:0]   sr_out,
    output logic [DATA_W-1:0] vbr_out,
    output logic [FC_W-1:0]   sfc_out,
    output logic [FC_W-1:0]   dfc_out,
    output logic [DATA_W-1:0] ssp_out,
    output logic [DATA_W-1:0] pc_out,
    output logic              done,
    output logic              running
);
    logic [NUM_VEC-1:0] cap;
    logic [DATA_W-1:0]  vec_q [NUM_VEC];

    rstvec_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .rd_ready(rd_ready), .rd_err(rd_err),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .cap(cap), .done(done), .running(running)
    );

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
        rstvec_vecreg #(.DATA_W(DATA_W)) u_vec (
            .clk(clk), .rst_n(rst_n),
            .cap(cap[i]), .err(rd_err), .data(rd_data),
            .q(vec_q[i])
        );
    end

    assign ssp_out = vec_q[VEC_SP];
    assign pc_out  = vec_q[VEC_PC];

    rstvec_ctlregs #(.SR_W(SR_W), .DATA_W(DATA_W), .FC_W(FC_W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .sr_q(sr_out), .vbr_q(vbr_out), .sfc_q(sfc_out), .dfc_q(dfc_out)
    );

    // R1: status word and vector base at their reset values once running
    assert_sr_vbr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (sr_out == SR_W'(16'h2700) && vbr_out == '0));

    // R2: function-code registers at 5 once running
    assert_fc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (sfc_out == FC_W'(5) && dfc_out == FC_W'(5)));

    // R10: loaded vectors are frozen in the run state
    assert_vec_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> ($stable(ssp_out) && $stable(pc_out)));

    // R3: only the two vector addresses are ever requested
    assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr == '0 || rd_addr == ADDR_W'(DATA_W / 8)));

endmodule

// File: tb/rstvec_seq_tb_top.sv
`timescale 1ns/1ps
module rstvec_seq_tb_top;

    typedef struct {
        logic [31:0] ssp;
        logic [31:0] pc;
        bit          sp_bad;
        bit          pc_bad;
    } exp_res_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req;
    logic [27:0] rd_addr;
    logic        rd_ready = 1'b0;
    logic        rd_err = 1'b0;
    logic [31:0] rd_data = '0;
    logic [15:0] sr_out;
    logic [31:0] vbr_out, ssp_out, pc_out;
    logic [2:0]  sfc_out, dfc_out;
    logic        done, running;

    int checks = 0;
    int errors = 0;
    int done_seen = 0;

    logic [27:0] exp_addr_q[$];
    exp_res_t    exp_res_q[$];

    logic [31:0] cfg_sp, cfg_pc;
    int          cfg_sp_mode, cfg_pc_mode;  // 0 clean, 1 error only, 2 error+ready
    int          cfg_lat;
    bit          noise_en = 1'b0;

    always #4 clk = ~clk;

    rstvec_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_err(rd_err), .rd_data(rd_data),
        .sr_out(sr_out), .vbr_out(vbr_out), .sfc_out(sfc_out), .dfc_out(dfc_out),
        .ssp_out(ssp_out), .pc_out(pc_out),
        .done(done), .running(running)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory responder
    initial begin
        int wcnt = 0;
        logic [31:0] lfsr = 32'h1234_5677;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                rd_ready = 0; rd_err = 0; wcnt = 0;
            end else if (noise_en) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                rd_ready = lfsr[3];
                rd_err   = lfsr[7];
                rd_data  = lfsr;
            end else if (rd_ready || rd_err) begin
                rd_ready = 0; rd_err = 0; wcnt = 0;
            end else if (rd_req) begin
                if (wcnt >= cfg_lat) begin
                    int m;
                    m = (rd_addr == 28'h0) ? cfg_sp_mode : cfg_pc_mode;
                    rd_ready = (m != 1);
                    rd_err   = (m != 0);
                    rd_data  = (m != 0) ? 32'hDEAD_BEEF :
                               ((rd_addr == 28'h0) ? cfg_sp : cfg_pc);
                end else begin
                    wcnt++;
                end
            end else begin
                wcnt = 0;
            end
        end
    end

    // Monitor / scoreboard
    initial begin
        bit          prev_wait = 0;
        logic [27:0] prev_addr = '0;
        bit          prev_done = 0;
        forever begin
            @(negedge clk);
            #1;
            if (!rst_n) begin
                prev_wait = 0; prev_done = 0;
            end else begin
                if (prev_wait)
                    check(rd_req && rd_addr == prev_addr, "R9", "held request address",
                          {4'h0, rd_addr}, {4'h0, prev_addr});
                if (running)
                    check(!rd_req, "R10", "request while running", {31'h0, rd_req}, 32'h0);
                if (rd_req && (rd_ready || rd_err) && !noise_en) begin
                    if (exp_addr_q.size() == 0) begin
                        check(0, "R4", "unexpected extra request", {4'h0, rd_addr}, 32'h0);
                    end else begin
                        logic [27:0] ea;
                        ea = exp_addr_q.pop_front();
                        check(rd_addr == ea, (ea == 28'h0) ? "R3" : "R4", "request address",
                              {4'h0, rd_addr}, {4'h0, ea});
                    end
                end
                if (done) begin
                    done_seen++;
                    check(!prev_done, "R7", "done wider than one cycle", 32'h1, 32'h0);
                    check(!running, "R8", "running during done", {31'h0, running}, 32'h0);
                    check(exp_addr_q.size() == 0, "R7", "done before both reads",
                          exp_addr_q.size(), 32'h0);
                    if (exp_res_q.size() == 0) begin
                        check(0, "R7", "unexpected done", 32'h1, 32'h0);
                    end else begin
                        exp_res_t e;
                        e = exp_res_q.pop_front();
                        check(ssp_out == e.ssp, e.sp_bad ? "R6" : "R5", "ssp_out", ssp_out, e.ssp);
                        check(pc_out == e.pc, e.pc_bad ? "R6" : "R5", "pc_out", pc_out, e.pc);
                    end
                end
                prev_wait = rd_req && !rd_ready && !rd_err;
                prev_addr = rd_addr;
                prev_done = done;
            end
        end
    end

    // Driver: one boot sequence
    task automatic run_case(input logic [31:0] sp, input logic [31:0] pc,
                            input int spm, input int pcm, input int lat);
        exp_res_t e;
        int start_done;
        int t;
        logic [31:0] ssp_hold, pc_hold;
        cfg_sp = sp; cfg_pc = pc; cfg_sp_mode = spm; cfg_pc_mode = pcm; cfg_lat = lat;
        noise_en = 0;
        @(negedge clk);
        rst_n = 0;
        exp_addr_q.push_back(28'h0000000);
        exp_addr_q.push_back(28'h0000004);
        e.ssp = (spm != 0) ? 32'h0 : sp;
        e.pc  = (pcm != 0) ? 32'h0 : pc;
        e.sp_bad = (spm != 0);
        e.pc_bad = (pcm != 0);
        exp_res_q.push_back(e);
        repeat (2) @(negedge clk);
        #1;
        // R1/R2/R3: reset state
        check(sr_out == 16'h2700, "R1", "sr_out in reset", {16'h0, sr_out}, 32'h2700);
        check(vbr_out == 0, "R1", "vbr_out in reset", vbr_out, 32'h0);
        check(sfc_out == 3'd5 && dfc_out == 3'd5, "R2", "function codes in reset",
              {26'h0, sfc_out, dfc_out}, {26'h0, 3'd5, 3'd5});
        check(!rd_req && !done && !running, "R3", "idle outputs in reset",
              {29'h0, rd_req, done, running}, 32'h0);
        @(negedge clk);
        rst_n = 1;
        start_done = done_seen;
        t = 0;
        while (done_seen == start_done && t < 200) begin
            @(negedge clk);
            t++;
        end
        check(done_seen == start_done + 1, "R7", "done pulse count", done_seen - start_done, 32'h1);
        @(negedge clk);
        #1;
        check(running && !done, "R8", "running after done", {30'h0, running, done}, 32'h2);
        check(sr_out == 16'h2700 && vbr_out == 0, "R1", "sr/vbr while running",
              {16'h0, sr_out}, 32'h2700);
        check(sfc_out == 3'd5 && dfc_out == 3'd5, "R2", "function codes while running",
              {29'h0, sfc_out}, 32'h5);
        ssp_hold = ssp_out;
        pc_hold = pc_out;
        start_done = done_seen;
        noise_en = 1;
        repeat (24) @(negedge clk);
        noise_en = 0;
        #1;
        check(ssp_out == ssp_hold, "R10", "ssp_out after port noise", ssp_out, ssp_hold);
        check(pc_out == pc_hold, "R10", "pc_out after port noise", pc_out, pc_hold);
        check(done_seen == start_done && running, "R10", "done after port noise",
              done_seen - start_done, 32'h0);
        check(exp_res_q.size() == 0 && exp_addr_q.size() == 0, "R4", "scoreboard drained",
              exp_addr_q.size() + exp_res_q.size(), 32'h0);
        exp_addr_q.delete();
        exp_res_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        run_case(32'h0000_8000, 32'h0000_0400, 0, 0, 0);  // R5 clean, no wait
        run_case(32'h00FF_FFFC, 32'h0012_3456, 0, 0, 3);  // R5, R9 with stalls
        run_case(32'h1111_1110, 32'h2222_2222, 1, 0, 1);  // R6 sp error only
        run_case(32'h3333_3330, 32'h4444_4444, 0, 2, 2);  // R6 pc error with ready
        run_case(32'h5555_5550, 32'h6666_6666, 2, 1, 0);  // R6 both faulted
        run_case(32'hFFFF_FFFE, 32'hFFFF_FFFF, 0, 0, 5);  // R5 all-ones data
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule